// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address straight to a real address through a small set of block-sized windows, without a page-table walk. Two banks of windows are held, one for instruction fetches and one for data accesses. Each window has an effective base, a mask, a real base, two privilege enables (supervisor and user) and a two-bit protection code. A lookup checks every window of the selected bank at once. The lowest-numbered window that is enabled for the current privilege, covers the address and allows the requested access provides the translation. A window that covers the address but refuses the access is passed over, and the search moves on to the next one.

A lookup is offered on a valid/ready request and answered one cycle later on a registered response. The response carries a hit flag, the real address, read/write/execute permissions and a virtual-page value built from the address and a segment identifier that the requester supplies. A miss tells the surrounding logic to fall back to page-table translation. The windows are loaded through a single-entry write port.

The response path is a two-state machine. In `ST_EMPTY` no response is held. It moves to `ST_HOLD` when a request is accepted. `ST_HOLD` stays in `ST_HOLD` while the consumer stalls, or when a new request is accepted in the cycle the current response is taken. It returns to `ST_EMPTY` when the response is taken and no request is offered.

Top module: `blkmap_xlate`

## Requirements
- R1: `req_data`=1 selects the data bank and 0 selects the instruction bank. On the write port, `cfg_bank`=1 writes the data bank and 0 writes the instruction bank, at entry `cfg_idx`. A window in one bank never affects lookups in the other bank.
- R2: With `req_user`=1 a window takes part only if its user enable is set. With `req_user`=0 a window takes part only if its supervisor enable is set.
- R3: A window covers the address when (`req_ea` AND mask) equals its effective base.
- R4: On a hit, `rsp_raddr` = real base OR (`req_ea` AND NOT mask).
- R5: On a hit, `rsp_rd`=1 (the protection code is nonzero), `rsp_wr`=1 exactly when the protection code is 2 or 3, and `rsp_ex`=1.
- R6: A covering window whose protection code is 0 is skipped. A covering window whose code is 1 is skipped on a write (`req_write`=1). In both cases the next window is tried.
- R7: When several windows qualify, the one with the lowest index is used.
- R8: When no window qualifies, the response has `rsp_hit`=0, `rsp_raddr`=0 and `rsp_rd`=`rsp_wr`=`rsp_ex`=0.
- R9: Every response carries `rsp_vpage` = {`req_vsid`, `req_ea[27:12]`}, so the address bits occupy bits 15:0 and the identifier starts at bit 16.
- R10: `req_ready` = NOT `rsp_valid` OR `rsp_ready`. An accepted request is answered with `rsp_valid`=1 on the next cycle. While `rsp_valid`=1 and `rsp_ready`=0, all response fields stay unchanged.
- R11: When a window write and an accepted lookup fall in the same cycle, the lookup uses the contents from before the write. The new contents apply from the next accepted request.
- R12: After reset every window is cleared (both enables 0, so nothing hits) and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_bank | input | 1 | Bank written: 1 data, 0 instruction |
| cfg_idx | input | IDX_W | Window index written |
| cfg_ebase | input | 32 | Effective base |
| cfg_mask | input | 32 | Compare mask |
| cfg_rbase | input | 32 | Real base |
| cfg_sv | input | 1 | Supervisor enable |
| cfg_uv | input | 1 | User enable |
| cfg_prot | input | 2 | Protection code |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | 1 data access, 0 instruction fetch |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| req_vsid | input | VSID_W | Segment identifier for the virtual page |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | A window translated the address |
| rsp_raddr | output | 32 | Real address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_vpage | output | VSID_W+16 | Virtual-page value |

## Verification
Two things can happen in the same cycle: a window write and the acceptance of a lookup that depends on that window. A second pair is a held response being taken while the next request is accepted. The bench provokes the first by driving `cfg_we` and `req_valid` together, on a window that changes the outcome. It provokes the second by lowering `rsp_ready` while requests queue, then raising it with a request waiting, and also does both at random. A behavioural reference model looks up windows as they stood before the clock edge and applies writes after it. It is compared with the ports on every cycle, so a lookup that sees the new contents, or a response that is lost or duplicated, shows up as a mismatch.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
    parameter int unsigned EA_W   = 32;
    parameter int unsigned PROT_W = 2;
    parameter int unsigned PG_SH  = 12;
    parameter int unsigned SEG_SH = 28;
    localparam int unsigned VP_LO_W = SEG_SH - PG_SH;

    typedef struct packed {
        logic [EA_W-1:0]   ebase;
        logic [EA_W-1:0]   mask;
        logic [EA_W-1:0]   rbase;
        logic              sv;
        logic              uv;
        logic [PROT_W-1:0] prot;
    } blk_ent_t;

    typedef struct packed {
        logic            hit;
        logic [EA_W-1:0] raddr;
        logic            rd;
        logic            wr;
        logic            ex;
    } blk_res_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/blkmap_regfile.sv
module blkmap_regfile
    import blkmap_pkg::*;
#(
    parameter int unsigned NUM_ENT = 8,
    localparam int unsigned IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  blk_ent_t         wr_ent,
    input  logic             rd_bank,
    output blk_ent_t         rd_ent [NUM_ENT]
);
    localparam int unsigned NUM_BANK = 2;

    blk_ent_t store [NUM_BANK][NUM_ENT];

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    store[b][e] <= '0;
                end else if (wr_en && (wr_bank == 1'(b)) && (wr_idx == IDX_W'(e))) begin
                    store[b][e] <= wr_ent;
                end
            end
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_rd
        assign rd_ent[e] = rd_bank ? store[1][e] : store[0][e];
    end
endmodule

// File: rtl/blkmap_search.sv
module blkmap_search
    import blkmap_pkg::*;
#(
    parameter int unsigned NUM_ENT = 8
) (
    input  blk_ent_t        ent [NUM_ENT],
    input  logic [EA_W-1:0] ea,
    input  logic            user,
    input  logic            write,
    output blk_res_t        res
);
    logic [NUM_ENT-1:0] qual;
    logic [NUM_ENT-1:0] can_wr;
    logic [EA_W-1:0]    raddr_v [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic enabled;
        logic covered;
        logic rd_ok;
        logic wr_ok;

        assign enabled    = user ? ent[g].uv : ent[g].sv;
        assign covered    = (ea & ent[g].mask) == ent[g].ebase;
        assign rd_ok      = |ent[g].prot;
        assign wr_ok      = |(ent[g].prot >> 1);
        assign qual[g]    = enabled && covered && rd_ok && (!write || wr_ok);
        assign can_wr[g]  = wr_ok;
        assign raddr_v[g] = ent[g].rbase | (ea & ~ent[g].mask);
    end

    // lowest index wins: scan from the top so the lowest qualifier is applied last
    always_comb begin
        res = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (qual[i]) begin
                res.hit   = 1'b1;
                res.raddr = raddr_v[i];
                res.rd    = 1'b1;
                res.wr    = can_wr[i];
                res.ex    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/blkmap_rspreg.sv
module blkmap_rspreg
    import blkmap_pkg::*;
#(
    parameter int unsigned VP_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  blk_res_t        nxt_res,
    input  logic [VP_W-1:0] nxt_vpage,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output blk_res_t        res_q,
    output logic [VP_W-1:0] vpage_q
);
    rsp_state_e state, state_nxt;
    logic       accept;

    assign req_ready = (state == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state == ST_HOLD);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nxt = ST_HOLD;
            ST_HOLD:  if (rsp_ready && !req_valid) state_nxt = ST_EMPTY;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            vpage_q <= '0;
        end else if (accept) begin
            res_q   <= nxt_res;
            vpage_q <= nxt_vpage;
        end
    end
endmodule

// File: rtl/blkmap_xlate.sv
module blkmap_xlate
    import blkmap_pkg::*;
#(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned VSID_W  = 24,
    localparam int unsigned IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int unsigned VP_W  = VSID_W + VP_LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_bank,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [EA_W-1:0]   cfg_ebase,
    input  logic [EA_W-1:0]   cfg_mask,
    input  logic [EA_W-1:0]   cfg_rbase,
    input  logic              cfg_sv,
    input  logic              cfg_uv,
    input  logic [PROT_W-1:0] cfg_prot,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_data,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [VSID_W-1:0] req_vsid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic [EA_W-1:0]   rsp_raddr,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_ex,
    output logic [VP_W-1:0]   rsp_vpage
);
    blk_ent_t cfg_ent;
    blk_ent_t sel_ent [NUM_ENT];
    blk_res_t look_res;
    blk_res_t res_q;
    logic [VP_W-1:0] look_vpage;

    assign cfg_ent = '{ebase: cfg_ebase, mask: cfg_mask, rbase: cfg_rbase,
                       sv: cfg_sv, uv: cfg_uv, prot: cfg_prot};

    assign look_vpage = {req_vsid, req_ea[SEG_SH-1:PG_SH]};

    blkmap_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_idx  (cfg_idx),
        .wr_ent  (cfg_ent),
        .rd_bank (req_data),
        .rd_ent  (sel_ent)
    );

    blkmap_search #(.NUM_ENT(NUM_ENT)) u_search (
        .ent   (sel_ent),
        .ea    (req_ea),
        .user  (req_user),
        .write (req_write),
        .res   (look_res)
    );

    blkmap_rspreg #(.VP_W(VP_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .nxt_res   (look_res),
        .nxt_vpage (look_vpage),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .res_q     (res_q),
        .vpage_q   (rsp_vpage)
    );

    assign rsp_hit   = res_q.hit;
    assign rsp_raddr = res_q.raddr;
    assign rsp_rd    = res_q.rd;
    assign rsp_wr    = res_q.wr;
    assign rsp_ex    = res_q.ex;
endmodule

// File: rtl/blkmap_checker.sv
module blkmap_checker #(
    parameter int unsigned VSID_W = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_write,
    input logic [31:0]           req_ea,
    input logic [VSID_W-1:0]     req_vsid,
    input logic                  rsp_valid,
    input logic                  rsp_ready,
    input logic                  rsp_hit,
    input logic [31:0]           rsp_raddr,
    input logic                  rsp_rd,
    input logic                  rsp_wr,
    input logic                  rsp_ex,
    input logic [VSID_W+15:0]    rsp_vpage
);
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_raddr)
                                       && $stable(rsp_rd) && $stable(rsp_wr) && $stable(rsp_vpage)));

    assert_accept_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid || rsp_ready) |-> req_ready);

    assert_hit_perms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_rd && rsp_ex));

    assert_write_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr) |-> rsp_rd);

    assert_write_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (!rsp_hit || rsp_wr));

    assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_raddr == 32'h0 && !rsp_rd && !rsp_wr && !rsp_ex));

    assert_vpage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_vpage == {$past(req_vsid), $past(req_ea[27:12])}));
endmodule

bind blkmap_xlate blkmap_checker #(.VSID_W(VSID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_ea    (req_ea),
    .req_vsid  (req_vsid),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_raddr (rsp_raddr),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr),
    .rsp_ex    (rsp_ex),
    .rsp_vpage (rsp_vpage)
);

// File: tb/sim_blkmap_xlate.sv
`timescale 1ns/1ps
module sim_blkmap_xlate;
    localparam int NE = 8;
    localparam int VW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_bank = 0, cfg_sv = 0, cfg_uv = 0;
    logic [2:0]  cfg_idx = 0;
    logic [31:0] cfg_ebase = 0, cfg_mask = 0, cfg_rbase = 0;
    logic [1:0]  cfg_prot = 0;
    logic        req_valid = 0, req_data = 0, req_write = 0, req_user = 0;
    logic [31:0] req_ea = 0;
    logic [VW-1:0] req_vsid = 0;
    logic        rsp_ready = 1;
    logic        req_ready, rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
    logic [31:0] rsp_raddr;
    logic [VW+15:0] rsp_vpage;

    always #2 clk = ~clk;   // 250 MHz

    blkmap_xlate u0 (.*);

    // ---------------- reference model ----------------
    logic [31:0] m_eb [2][NE];
    logic [31:0] m_mk [2][NE];
    logic [31:0] m_rb [2][NE];
    logic        m_sv [2][NE];
    logic        m_uv [2][NE];
    logic [1:0]  m_pp [2][NE];
    logic        e_valid, e_hit, e_rd, e_wr, e_ex;
    logic [31:0] e_raddr;
    logic [VW+15:0] e_vpage;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < NE; i++) begin
                    m_eb[b][i] = 0; m_mk[b][i] = 0; m_rb[b][i] = 0;
                    m_sv[b][i] = 0; m_uv[b][i] = 0; m_pp[b][i] = 0;
                end
            e_valid = 0; e_hit = 0; e_rd = 0; e_wr = 0; e_ex = 0; e_raddr = 0; e_vpage = 0;
        end else begin
            if (req_valid && (!e_valid || rsp_ready)) begin
                int bk;
                bit found;
                bk = req_data ? 1 : 0;
                found = 0;
                e_hit = 0; e_rd = 0; e_wr = 0; e_ex = 0; e_raddr = 0;
                for (int i = 0; i < NE; i++) begin
                    if (!found && (req_user ? m_uv[bk][i] : m_sv[bk][i])
                        && ((req_ea & m_mk[bk][i]) == m_eb[bk][i])
                        && (m_pp[bk][i] != 0)
                        && (!req_write || m_pp[bk][i] >= 2)) begin
                        found = 1;
                        e_hit = 1; e_rd = 1; e_ex = 1;
                        e_wr = (m_pp[bk][i] >= 2);
                        e_raddr = m_rb[bk][i] | (req_ea & ~m_mk[bk][i]);
                    end
                end
                e_vpage = {req_vsid, req_ea[27:12]};
                e_valid = 1;
            end else if (rsp_ready) begin
                e_valid = 0;
            end
            if (cfg_we) begin
                m_eb[cfg_bank][cfg_idx] = cfg_ebase;
                m_mk[cfg_bank][cfg_idx] = cfg_mask;
                m_rb[cfg_bank][cfg_idx] = cfg_rbase;
                m_sv[cfg_bank][cfg_idx] = cfg_sv;
                m_uv[cfg_bank][cfg_idx] = cfg_uv;
                m_pp[cfg_bank][cfg_idx] = cfg_prot;
            end
        end
    end

    // ---------------- checking ----------------
    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R12";

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk("rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk("req_ready", 64'(req_ready), 64'(!e_valid || rsp_ready));
        if (e_valid) begin
            chk("rsp_hit",   64'(rsp_hit),   64'(e_hit));
            chk("rsp_raddr", 64'(rsp_raddr), 64'(e_raddr));
            chk("rsp_rd",    64'(rsp_rd),    64'(e_rd));
            chk("rsp_wr",    64'(rsp_wr),    64'(e_wr));
            chk("rsp_ex",    64'(rsp_ex),    64'(e_ex));
            chk("rsp_vpage", 64'(rsp_vpage), 64'(e_vpage));
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=below 150000", cyc);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic set_win(bit bank, int idx, logic [31:0] eb, logic [31:0] mk,
                           logic [31:0] rb, bit sv, bit uv, logic [1:0] pp);
        cfg_we = 1; cfg_bank = bank; cfg_idx = 3'(idx);
        cfg_ebase = eb; cfg_mask = mk; cfg_rbase = rb;
        cfg_sv = sv; cfg_uv = uv; cfg_prot = pp;
    endtask

    task automatic set_req(logic [31:0] ea, bit dat, bit wr, bit usr, logic [VW-1:0] vs);
        req_valid = 1; req_ea = ea; req_data = dat; req_write = wr; req_user = usr; req_vsid = vs;
    endtask

    task automatic idle();
        cfg_we = 0; req_valid = 0;
    endtask

    task automatic wr_win(bit bank, int idx, logic [31:0] eb, logic [31:0] mk,
                          logic [31:0] rb, bit sv, bit uv, logic [1:0] pp);
        step(); set_win(bank, idx, eb, mk, rb, sv, uv, pp);
        step(); idle();
    endtask

    task automatic look(logic [31:0] ea, bit dat, bit wr, bit usr, logic [VW-1:0] vs);
        step(); set_req(ea, dat, wr, usr, vs);
        step(); idle();
        step();
    endtask

    function automatic logic [31:0] pick_mask(int k);
        case (k % 4)
            0: return 32'hF000_0000;
            1: return 32'hFF00_0000;
            2: return 32'hFFF0_0000;
            default: return 32'hFFFE_0000;
        endcase
    endfunction

    initial begin
        repeat (3) step();
        cur_tag = "R12";
        rst_n = 1;
        step();
        look(32'h1234_5678, 0, 0, 0, 24'h00_0001);   // R12: all windows clear -> miss
        look(32'h1234_5678, 1, 0, 1, 24'h00_0002);

        // R3 / R4: instruction window 0 covers 0x1xxx_xxxx
        cur_tag = "R3";
        wr_win(0, 0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 1, 0, 2'd2);
        look(32'h1234_5678, 0, 0, 0, 24'hABCDEF);
        look(32'h2234_5678, 0, 0, 0, 24'hABCDEF);
        cur_tag = "R4";
        wr_win(0, 1, 32'h2200_0000, 32'hFF00_0000, 32'h0500_0000, 1, 0, 2'd3);
        look(32'h22AB_CDEF, 0, 0, 0, 24'h123456);

        // R1: same address in data bank misses, then own data window
        cur_tag = "R1";
        look(32'h1234_5678, 1, 0, 0, 24'h000111);
        wr_win(1, 0, 32'h1000_0000, 32'hF000_0000, 32'h4000_0000, 1, 1, 2'd1);
        look(32'h1234_5678, 1, 0, 0, 24'h000111);
        look(32'h1234_5678, 0, 0, 0, 24'h000111);

        // R2: privilege enables
        cur_tag = "R2";
        look(32'h1234_5678, 0, 0, 1, 24'h000222);    // instr window 0 user-disabled
        look(32'h1234_5678, 1, 0, 1, 24'h000222);    // data window 0 user-enabled
        wr_win(0, 2, 32'h3000_0000, 32'hF000_0000, 32'h6000_0000, 0, 1, 2'd2);
        look(32'h3000_1000, 0, 0, 0, 24'h000223);    // supervisor: disabled -> miss
        look(32'h3000_1000, 0, 0, 1, 24'h000223);

        // R5: permission outputs
        cur_tag = "R5";
        look(32'h1000_0ABC, 1, 0, 0, 24'h000333);    // prot 1: read only
        look(32'h1000_0ABC, 0, 1, 0, 24'h000333);    // prot 2: write ok

        // R6: denial falls through
        cur_tag = "R6";
        look(32'h1000_0ABC, 1, 1, 0, 24'h000444);    // write to read-only -> miss
        wr_win(1, 1, 32'h1000_0000, 32'hFFF0_0000, 32'h7700_0000, 1, 0, 2'd3);
        look(32'h1000_0ABC, 1, 1, 0, 24'h000444);    // skips 0, uses 1
        wr_win(1, 0, 32'h1000_0000, 32'hF000_0000, 32'h4000_0000, 1, 1, 2'd0);
        look(32'h1000_0ABC, 1, 0, 0, 24'h000445);    // prot 0 skipped on read

        // R7: lowest index wins
        cur_tag = "R7";
        wr_win(1, 5, 32'h5000_0000, 32'hF000_0000, 32'hA000_0000, 1, 1, 2'd2);
        wr_win(1, 3, 32'h5000_0000, 32'hFF00_0000, 32'hB000_0000, 1, 1, 2'd2);
        look(32'h5012_3456, 1, 0, 0, 24'h000555);
        look(32'h5112_3456, 1, 0, 1, 24'h000556);

        // R9: identifier extremes
        cur_tag = "R9";
        look(32'hFFFF_FFFF, 0, 0, 0, 24'hFFFFFF);
        look(32'h0FFF_F000, 1, 0, 0, 24'h800001);

        // R10: stall with queued request, then release
        cur_tag = "R10";
        step(); rsp_ready = 0; set_req(32'h5012_0000, 1, 0, 0, 24'h000A01);
        step(); set_req(32'h1234_5678, 0, 0, 0, 24'h000A02);
        step(); step(); step();
        rsp_ready = 1;
        step(); idle();
        step(); step();

        // R11: write and lookup in the same cycle
        cur_tag = "R11";
        step(); set_req(32'h6000_0040, 1, 0, 0, 24'h000B01);
        set_win(1, 2, 32'h6000_0000, 32'hF000_0000, 32'hC000_0000, 1, 0, 2'd2);
        step(); idle();
        look(32'h6000_0040, 1, 0, 0, 24'h000B02);
        step(); set_req(32'h6000_0040, 1, 0, 0, 24'h000B03);
        set_win(1, 2, 32'h0, 32'h0, 32'h0, 0, 0, 2'd0);
        step(); idle();
        look(32'h6000_0040, 1, 0, 0, 24'h000B04);

        // random mix of everything, including stalls and same-cycle writes
        for (int n = 0; n < 4000; n++) begin
            step();
            idle();
            rsp_ready = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) begin
                logic [31:0] mk;
                mk = pick_mask(int'($urandom % 4));
                set_win(1'($urandom % 2), int'($urandom % NE),
                        {4'($urandom % 4), 28'($urandom)} & mk, mk,
                        $urandom & mk, 1'($urandom), 1'($urandom), 2'($urandom));
            end
            if (($urandom % 2) == 0)
                set_req({4'($urandom % 4), 28'($urandom)}, 1'($urandom), 1'($urandom),
                        1'($urandom), VW'($urandom));
        end
        step(); idle(); rsp_ready = 1;
        repeat (4) step();
        summary();
    end
endmodule